// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the live calendar of a real-time clock and decides, once per second, whether the programmed alarm time has come. Seven alarm fields are held locally: seconds, minutes, hours, weekday, date, month and year. After each one-second update strobe, the block waits one cycle for the calendar counters to settle. It then compares every field with the matching counter value. A field whose bits are all one takes no part in the comparison, so a single alarm setting can fire daily, hourly, on a given weekday, and so on.

A full match sets a sticky alarm flag, which software clears with a write-one-to-clear strobe. If the system is powered down at that moment, a one-cycle wake request is also issued. Reset loads the month alarm field with 00, which no calendar month can equal, so a freshly reset block never fires until it has been programmed.

The sequencing is a three-state machine:
- **ST_IDLE** waits for the strobe. The transition *tick_seen* leads to **ST_SETTLE**.
- **ST_SETTLE** always takes *settled* to **ST_EVAL**.
- **ST_EVAL** always takes *done* back to **ST_IDLE**, and registers the result of the comparison on that edge.

A strobe that arrives outside ST_IDLE is ignored.

Top module: `cal_alarm_match`

## Requirements
- R1: Two clock edges after the edge that samples `tick` high, the block compares all seven alarm fields with the calendar inputs. If every field that takes part matches, `alarm_flag` is 1 from that edge onward.
- R2: An 8-bit alarm field holding FFH takes no part in the comparison.
- R3: The weekday alarm field is 3 bits wide and is written from `wr_data[2:0]`. Its wildcard value is 7.
- R4: After reset, `alarm_flag` and `wake_req` are 0. The month alarm field holds 00H and every other field holds its wildcard value, so no calendar value can produce a match.
- R5: Without a `tick`, `alarm_flag` never rises, even when the calendar matches the alarm.
- R6: `alarm_flag` stays 1 until `clr_alarm` is sampled high; the edge after that leaves it 0. If a new match is registered on the same edge as a clear, the flag stays 1.
- R7: `wake_req` is high for exactly the one cycle after the match edge, and only if `pwr_off` was 1 at that edge. Otherwise it stays 0.
- R8: With every field at its wildcard value, each `tick` produces a match, whatever the calendar values are.
- R9: `wr_sel` chooses the field written on a `wr_en` cycle: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year. A write with `wr_sel` = 7 changes no field.
- R10: A mismatch in any single field that takes part in the comparison stops the flag from being set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second calendar update strobe |
| pwr_off | input | 1 | System is powered down |
| cur_sec | input | 8 | Calendar seconds (BCD) |
| cur_min | input | 8 | Calendar minutes (BCD) |
| cur_hour | input | 8 | Calendar hours (BCD) |
| cur_dow | input | 3 | Calendar weekday, 0 to 6 |
| cur_date | input | 8 | Calendar date (BCD) |
| cur_month | input | 8 | Calendar month (BCD) |
| cur_year | input | 8 | Calendar year (BCD) |
| wr_en | input | 1 | Alarm field write enable |
| wr_sel | input | 3 | Alarm field select |
| wr_data | input | 8 | Alarm field write data |
| clr_alarm | input | 1 | Write-one-to-clear for the alarm flag |
| alarm_flag | output | 1 | Sticky alarm indication |
| wake_req | output | 1 | One-cycle power-up request |

## Verification
The comparison is driven with four kinds of input pattern:
- **Exact match on all seven fields.** This separates a working comparator from one that never fires.
- **One field off by one, first seconds and then weekday.** This shows that every field really takes part in the comparison.
- **The same mismatches with that field set to wildcard.** This separates correct wildcard decoding from a plain equality test. The weekday case tells the 3-bit wildcard 7 apart from FFH.
- **All fields wildcard, with arbitrary calendar values.** This confirms that the alarm fires on every second.

Ticks with `pwr_off` high and low show that the wake request follows the power state. A clear placed on the match edge shows that a new match takes priority over the clear.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int SEL_W      = 3;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DOW   = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6
    } field_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_EVAL   = 2'd2
    } alarm_state_e;

endpackage

// File: rtl/alarm_field_regs.sv
module alarm_field_regs
    import cal_alarm_pkg::*;
#(
    parameter int FW    = 8,
    parameter int DOW_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [FW-1:0]        wr_data,
    output logic [FW-1:0]        field_q [NUM_FIELDS]
);

    localparam logic [FW-1:0] DOW_MASK = FW'((1 << DOW_W) - 1);

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam logic [FW-1:0] RST_VAL =
            (i == int'(FLD_MONTH)) ? '0 :
            (i == int'(FLD_DOW))   ? DOW_MASK : '1;
        localparam logic [FW-1:0] KEEP =
            (i == int'(FLD_DOW)) ? DOW_MASK : '1;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                field_q[i] <= RST_VAL;
            end else if (wr_en && (wr_sel == SEL_W'(i))) begin
                field_q[i] <= wr_data & KEEP;
            end
        end
    end

endmodule

// File: rtl/alarm_field_match.sv
module alarm_field_match #(
    parameter int FW    = 8,
    parameter int ACT_W = 8
) (
    input  logic [FW-1:0] alarm_val,
    input  logic [FW-1:0] cur_val,
    output logic          hit
);

    localparam logic [FW-1:0] MASK = FW'((1 << ACT_W) - 1);

    logic is_wild;
    logic is_equal;

    always_comb begin
        is_wild  = &(alarm_val | ~MASK);
        is_equal = ((alarm_val ^ cur_val) & MASK) == '0;
        hit      = is_wild | is_equal;
    end

endmodule

// File: rtl/alarm_seq_fsm.sv
module alarm_seq_fsm
    import cal_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic all_hit,
    input  logic pwr_off,
    input  logic clr_alarm,
    output logic alarm_flag,
    output logic wake_req
);

    alarm_state_e state_q;
    alarm_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick) state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_EVAL;
            ST_EVAL:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    logic fire;
    assign fire = (state_q == ST_EVAL) && all_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_flag <= 1'b0;
            wake_req   <= 1'b0;
        end else begin
            wake_req <= fire && pwr_off;
            if (fire) begin
                alarm_flag <= 1'b1;
            end else if (clr_alarm) begin
                alarm_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
#(
    parameter int FW    = 8,
    parameter int DOW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pwr_off,
    input  logic [FW-1:0]    cur_sec,
    input  logic [FW-1:0]    cur_min,
    input  logic [FW-1:0]    cur_hour,
    input  logic [DOW_W-1:0] cur_dow,
    input  logic [FW-1:0]    cur_date,
    input  logic [FW-1:0]    cur_month,
    input  logic [FW-1:0]    cur_year,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [FW-1:0]    wr_data,
    input  logic             clr_alarm,
    output logic             alarm_flag,
    output logic             wake_req
);

    logic [FW-1:0]         field_q [NUM_FIELDS];
    logic [FW-1:0]         cur_vec [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] hits;
    logic                  all_hit;

    always_comb begin
        cur_vec[FLD_SEC]   = cur_sec;
        cur_vec[FLD_MIN]   = cur_min;
        cur_vec[FLD_HOUR]  = cur_hour;
        cur_vec[FLD_DOW]   = FW'(cur_dow);
        cur_vec[FLD_DATE]  = cur_date;
        cur_vec[FLD_MONTH] = cur_month;
        cur_vec[FLD_YEAR]  = cur_year;
    end

    alarm_field_regs #(.FW(FW), .DOW_W(DOW_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .field_q (field_q)
    );

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        localparam int ACT = (i == int'(FLD_DOW)) ? DOW_W : FW;
        alarm_field_match #(.FW(FW), .ACT_W(ACT)) u_match (
            .alarm_val (field_q[i]),
            .cur_val   (cur_vec[i]),
            .hit       (hits[i])
        );
    end

    assign all_hit = &hits;

    alarm_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .all_hit    (all_hit),
        .pwr_off    (pwr_off),
        .clr_alarm  (clr_alarm),
        .alarm_flag (alarm_flag),
        .wake_req   (wake_req)
    );

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic pwr_off,
    input logic clr_alarm,
    input logic alarm_flag,
    input logic wake_req
);

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);                                  // R7

    AST_WAKE_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(pwr_off));                             // R7

    AST_WAKE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> alarm_flag);                                 // R7

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !clr_alarm) |=> alarm_flag);               // R6

    AST_SET_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(tick, 3));                    // R5

endmodule

bind cal_alarm_match cal_alarm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pwr_off    (pwr_off),
    .clr_alarm  (clr_alarm),
    .alarm_flag (alarm_flag),
    .wake_req   (wake_req)
);

// File: tb/cal_alarm_match_tb.sv
module cal_alarm_match_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       pwr_off = 1'b0;
    logic [7:0] cur_sec = 8'h56, cur_min = 8'h34, cur_hour = 8'h12;
    logic [2:0] cur_dow = 3'd2;
    logic [7:0] cur_date = 8'h15, cur_month = 8'h06, cur_year = 8'h24;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       clr_alarm = 1'b0;
    logic       alarm_flag;
    logic       wake_req;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    cal_alarm_match u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_off(pwr_off),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_dow(cur_dow), .cur_date(cur_date), .cur_month(cur_month),
        .cur_year(cur_year), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .clr_alarm(clr_alarm),
        .alarm_flag(alarm_flag), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); clr_alarm = 1'b1;
        @(negedge clk); clr_alarm = 1'b0;
    endtask

    // pulse tick; return at the negedge after the match edge
    task automatic do_tick(input bit clr_on_match);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk); clr_alarm = clr_on_match;
        @(negedge clk); clr_alarm = 1'b0;
    endtask

    task automatic program_exact();
        wr(3'd0, 8'h56); wr(3'd1, 8'h34); wr(3'd2, 8'h12); wr(3'd3, 8'h02);
        wr(3'd4, 8'h15); wr(3'd5, 8'h06); wr(3'd6, 8'h24);
    endtask

    task automatic t_reset();
        chk("R4 flag after reset", alarm_flag, 1'b0);
        chk("R4 wake after reset", wake_req, 1'b0);
        do_tick(0);
        chk("R4 month 00 blocks match", alarm_flag, 1'b0);
    endtask

    task automatic t_exact();
        program_exact();
        repeat (6) @(negedge clk);
        chk("R5 no tick no flag", alarm_flag, 1'b0);
        do_tick(0);
        chk("R1 exact match sets flag", alarm_flag, 1'b1);
        chk("R7 no wake when powered", wake_req, 1'b0);
    endtask

    task automatic t_sticky();
        repeat (5) @(negedge clk);
        chk("R6 flag sticky", alarm_flag, 1'b1);
        clear_flag();
        chk("R6 clear drops flag", alarm_flag, 1'b0);
        do_tick(1);
        chk("R6 set wins over clear", alarm_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_fields();
        cur_sec = 8'h57;
        do_tick(0);
        chk("R10 seconds mismatch", alarm_flag, 1'b0);
        wr(3'd0, 8'hFF);
        do_tick(0);
        chk("R2 seconds wildcard", alarm_flag, 1'b1);
        clear_flag();
        cur_dow = 3'd3;
        do_tick(0);
        chk("R10 weekday mismatch", alarm_flag, 1'b0);
        wr(3'd3, 8'hF7);
        do_tick(0);
        chk("R3 weekday wildcard 7", alarm_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_wake();
        pwr_off = 1'b1;
        do_tick(0);
        chk("R7 wake pulse when off", wake_req, 1'b1);
        @(negedge clk);
        chk("R7 wake one cycle", wake_req, 1'b0);
        pwr_off = 1'b0;
        clear_flag();
    endtask

    task automatic t_all_wild();
        for (int i = 0; i < 7; i++) wr(3'(i), 8'hFF);
        cur_sec = 8'h01; cur_min = 8'h59; cur_hour = 8'h23; cur_dow = 3'd6;
        cur_date = 8'h31; cur_month = 8'h12; cur_year = 8'h99;
        do_tick(0);
        chk("R8 all wildcard fires", alarm_flag, 1'b1);
        clear_flag();
        cur_sec = 8'h02;
        do_tick(0);
        chk("R8 fires next second", alarm_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_sel();
        wr(3'd5, 8'h12);
        wr(3'd7, 8'h00);
        do_tick(0);
        chk("R9 sel 7 writes nothing", alarm_flag, 1'b1);
        clear_flag();
        wr(3'd6, 8'h98);
        do_tick(0);
        chk("R9 sel 6 is year", alarm_flag, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact();
        t_sticky();
        t_fields();
        t_wake();
        t_all_wild();
        t_sel();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule